// File: doc/BRIEF.md
# Halt Entry and Wake Controller

This block moves a processor core into one of four low-power halt levels and brings it back when an interrupt arrives. The core issues a one-cycle halt command together with a level code. The block then drops the clock enables that the chosen level requires. Three kinds of request can wake it:

- a non-maskable line and an external interrupt line, each edge-detected inside the block;
- a level-type request from any other interrupt source, which carries its own priority.

The two deep levels (light idle and stop) pass through a settling window of `WIN_CYC` cycles before the halt is complete. A rising edge on the non-maskable or external line inside that window does not wake the core. It is stored as pending instead. When a later request releases the halt, the stored requests and the new one are ranked, and they are reported one per cycle on a dispatch strobe with an identity code, highest rank first. The two shallow levels (run-halt and full idle) have no window and halt at once.

Top module: `halt_wake_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to the running state with nothing pending. After that edge `halted`=0, all three clock enables are 1, `wake_vld`=0 and `wake_id`=3.
- R2: A `halt_req` accepted with `halt_mode` 0 (run-halt) or 1 (full idle) makes `halted` 1 from the next cycle.
- R3: A `halt_req` accepted with `halt_mode` 2 (light idle) or 3 (stop) opens a window of `WIN_CYC` cycles, default 3. `halted` becomes 1 on the cycle after the window ends, which is `WIN_CYC`+1 cycles after the command is sampled.
- R4: While halted, `core_clk_en` is 0. `periph_clk_en` is 0 only for modes 2 and 3, and `osc_en` is 0 only for mode 3. In every other state all three enables are 1, including during the window.
- R5: A rising edge on `nmi_lvl` or `ext_lvl` during the window does not release the halt. It is stored as pending, and a level on `oth_req` during the window has no effect.
- R6: While halted, a rising edge on `nmi_lvl` or `ext_lvl`, or `oth_req` high, releases the halt. On the next cycle `halted` is 0 and `wake_vld` is 1.
- R7: After release, pending and new requests are dispatched one per cycle, starting in the first cycle after release. `wake_id` is 0 for the non-maskable source, 1 for external and 2 for other, and 3 when `wake_vld` is 0. The non-maskable source is always first. The other source goes before external only if its captured `oth_pri` is strictly greater than `EXT_PRI` (default 4).
- R8: An external edge pending from the window, together with a new external edge that releases the halt, is dispatched once.
- R9: `halt_req` is ignored unless the block is running with no dispatch in progress. This covers the window, the halted state and dispatch cycles.
- R10: A reset during the window discards anything pending, so a later wake dispatches only the new request.
- R11: `oth_req` held high through the window wakes the core on the first halted cycle. `halted` is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halt_req | input | 1 | One-cycle halt command |
| halt_mode | input | 2 | Halt level: 0 run-halt, 1 full idle, 2 light idle, 3 stop |
| nmi_lvl | input | 1 | Non-maskable request line, rising edge active |
| ext_lvl | input | 1 | External interrupt line, rising edge active |
| oth_req | input | 1 | Wake request from any other interrupt, level |
| oth_pri | input | PRI_W | Priority of the other request |
| halted | output | 1 | Core fully halted |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| wake_vld | output | 1 | Dispatch strobe, one cycle per request |
| wake_id | output | 2 | Identity of the dispatched request |

## Verification
A wrong window count shows up as `halted` rising a cycle early or late after a deep command. A lost pending bit shows up as a missing second dispatch pulse in the cycle right after the first one. A bad ranking swaps the two `wake_id` values in those two consecutive cycles. A stuck state shows within one cycle as clock enables that do not match the level. The bench's reference model predicts all outputs every cycle, so each of these faults appears at the first clock where the outputs diverge.

// File: rtl/hwc_pkg.sv
package hwc_pkg;

  typedef enum logic [1:0] {
    HM_RUN   = 2'd0,
    HM_IDLE2 = 2'd1,
    HM_IDLE1 = 2'd2,
    HM_STOP  = 2'd3
  } hmode_t;

  typedef enum logic [1:0] {
    WID_NMI  = 2'd0,
    WID_EXT  = 2'd1,
    WID_OTH  = 2'd2,
    WID_NONE = 2'd3
  } wid_t;

  typedef enum logic [1:0] {
    SQ_ACT  = 2'd0,
    SQ_WIN  = 2'd1,
    SQ_HALT = 2'd2
  } sq_t;

  // deep levels have a settling window
  function automatic logic is_deep(logic [1:0] m);
    return m[1];
  endfunction

endpackage

// File: rtl/hwc_edge.sv
module hwc_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic prev_q;
    always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl[i];
    end
    assign rise[i] = lvl[i] & ~prev_q;
  end

endmodule

// File: rtl/hwc_seq.sv
module hwc_seq
  import hwc_pkg::*;
#(
  parameter int WIN_CYC = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt_req,
  input  logic [1:0] halt_mode,
  input  logic       disp_idle,
  input  logic       wake_evt,
  output logic       accept,
  output logic       win_act,
  output logic       halted,
  output hmode_t     lat_mode
);

  localparam int CNT_W = $clog2(WIN_CYC + 1);

  sq_t              st_q;
  logic [CNT_W-1:0] cnt_q;

  assign accept  = halt_req && (st_q == SQ_ACT) && disp_idle;
  assign win_act = (st_q == SQ_WIN);
  assign halted  = (st_q == SQ_HALT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= SQ_ACT;
      cnt_q    <= '0;
      lat_mode <= HM_RUN;
    end else begin
      case (st_q)
        SQ_ACT: if (accept) begin
          lat_mode <= hmode_t'(halt_mode);
          if (is_deep(halt_mode)) begin
            st_q  <= SQ_WIN;
            cnt_q <= CNT_W'(WIN_CYC - 1);
          end else begin
            st_q <= SQ_HALT;
          end
        end
        SQ_WIN: begin
          if (cnt_q == '0) st_q <= SQ_HALT;
          else             cnt_q <= cnt_q - 1'b1;
        end
        SQ_HALT: if (wake_evt) st_q <= SQ_ACT;
        default: st_q <= SQ_ACT;
      endcase
    end
  end

endmodule

// File: rtl/hwc_disp.sv
module hwc_disp
  import hwc_pkg::*;
#(
  parameter int PRI_W   = 3,
  parameter int EXT_PRI = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_act,
  input  logic             wake_evt,
  input  logic             nmi_e,
  input  logic             ext_e,
  input  logic             oth_req,
  input  logic [PRI_W-1:0] oth_pri,
  output logic             wake_vld,
  output wid_t             wake_id,
  output logic             disp_idle
);

  localparam logic [PRI_W-1:0] EXT_LVL = PRI_W'(EXT_PRI);

  // ranking: non-maskable first, then other only if strictly above external
  function automatic wid_t pick_src(logic n, logic e, logic o, logic [PRI_W-1:0] p);
    if (n)           return WID_NMI;
    if (e && o)      return (p > EXT_LVL) ? WID_OTH : WID_EXT;
    if (e)           return WID_EXT;
    if (o)           return WID_OTH;
    return WID_NONE;
  endfunction

  logic             pend_n, pend_e;
  logic             owe_n, owe_e, owe_o;
  logic [PRI_W-1:0] opri;
  wid_t             sel;

  assign sel       = pick_src(owe_n, owe_e, owe_o, opri);
  assign wake_vld  = (sel != WID_NONE);
  assign wake_id   = sel;
  assign disp_idle = !wake_vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_n <= 1'b0;
      pend_e <= 1'b0;
      owe_n  <= 1'b0;
      owe_e  <= 1'b0;
      owe_o  <= 1'b0;
      opri   <= '0;
    end else begin
      if (win_act) begin
        pend_n <= pend_n | nmi_e;
        pend_e <= pend_e | ext_e;
      end
      if (wake_evt) begin
        owe_n  <= pend_n | nmi_e;
        owe_e  <= pend_e | ext_e;
        owe_o  <= oth_req;
        opri   <= oth_pri;
        pend_n <= 1'b0;
        pend_e <= 1'b0;
      end else begin
        if (sel == WID_NMI) owe_n <= 1'b0;
        if (sel == WID_EXT) owe_e <= 1'b0;
        if (sel == WID_OTH) owe_o <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl
  import hwc_pkg::*;
#(
  parameter int WIN_CYC = 3,
  parameter int PRI_W   = 3,
  parameter int EXT_PRI = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt_req,
  input  logic [1:0]       halt_mode,
  input  logic             nmi_lvl,
  input  logic             ext_lvl,
  input  logic             oth_req,
  input  logic [PRI_W-1:0] oth_pri,
  output logic             halted,
  output logic             core_clk_en,
  output logic             periph_clk_en,
  output logic             osc_en,
  output logic             wake_vld,
  output logic [1:0]       wake_id
);

  logic   [1:0] rise;
  logic         nmi_e, ext_e;
  logic         win_act, wake_evt, disp_idle, accept;
  hmode_t       lat_mode;
  wid_t         disp_id;

  hwc_edge #(.N(2)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  ({ext_lvl, nmi_lvl}),
    .rise (rise)
  );
  assign nmi_e = rise[0];
  assign ext_e = rise[1];

  assign wake_evt = halted && (nmi_e || ext_e || oth_req);

  hwc_seq #(.WIN_CYC(WIN_CYC)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .halt_req (halt_req),
    .halt_mode(halt_mode),
    .disp_idle(disp_idle),
    .wake_evt (wake_evt),
    .accept   (accept),
    .win_act  (win_act),
    .halted   (halted),
    .lat_mode (lat_mode)
  );

  hwc_disp #(.PRI_W(PRI_W), .EXT_PRI(EXT_PRI)) u_disp (
    .clk      (clk),
    .rst_n    (rst_n),
    .win_act  (win_act),
    .wake_evt (wake_evt),
    .nmi_e    (nmi_e),
    .ext_e    (ext_e),
    .oth_req  (oth_req),
    .oth_pri  (oth_pri),
    .wake_vld (wake_vld),
    .wake_id  (disp_id),
    .disp_idle(disp_idle)
  );

  assign wake_id       = disp_id;
  assign core_clk_en   = !halted;
  assign periph_clk_en = !(halted && is_deep(lat_mode));
  assign osc_en        = !(halted && (lat_mode == HM_STOP));

endmodule

// File: rtl/halt_wake_ctrl_chk.sv
module halt_wake_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       halt_req,
  input logic [1:0] halt_mode,
  input logic       halted,
  input logic       core_clk_en,
  input logic       periph_clk_en,
  input logic       osc_en,
  input logic       wake_vld,
  input logic [1:0] wake_id,
  input logic       accept,
  input logic       win_act,
  input logic       wake_evt,
  input logic       nmi_e,
  input logic       ext_e,
  input logic [1:0] lat_mode
);

  // R2
  shallow_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !halt_mode[1]) |=> halted);

  // R3
  deep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(halted) && lat_mode[1]) |-> $past(win_act));

  // R4
  core_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !core_clk_en);

  // R4
  run_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !halted |-> (core_clk_en && periph_clk_en && osc_en));

  // R5
  window_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_act && (nmi_e || ext_e)) |=> !wake_vld);

  // R6
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && wake_evt) |=> (!halted && wake_vld));

  // R7
  nmi_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_vld && wake_id == 2'd0) |=> !(wake_vld && wake_id == 2'd0));

  // R9
  window_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_act && halt_req) |=> $stable(lat_mode));

endmodule

bind halt_wake_ctrl halt_wake_ctrl_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .halt_req     (halt_req),
  .halt_mode    (halt_mode),
  .halted       (halted),
  .core_clk_en  (core_clk_en),
  .periph_clk_en(periph_clk_en),
  .osc_en       (osc_en),
  .wake_vld     (wake_vld),
  .wake_id      (wake_id),
  .accept       (accept),
  .win_act      (win_act),
  .wake_evt     (wake_evt),
  .nmi_e        (nmi_e),
  .ext_e        (ext_e),
  .lat_mode     (lat_mode)
);

// File: tb/halt_wake_ctrl_tb_top.sv
module halt_wake_ctrl_tb_top;

  localparam int WIN     = 3;
  localparam int EXT_LVL = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       halt_req = 1'b0;
  logic [1:0] halt_mode = 2'd0;
  logic       nmi_lvl = 1'b0;
  logic       ext_lvl = 1'b0;
  logic       oth_req = 1'b0;
  logic [2:0] oth_pri = 3'd0;
  logic       halted, core_clk_en, periph_clk_en, osc_en, wake_vld;
  logic [1:0] wake_id;

  always #10 clk = ~clk;

  halt_wake_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .halt_mode(halt_mode),
    .nmi_lvl(nmi_lvl), .ext_lvl(ext_lvl), .oth_req(oth_req), .oth_pri(oth_pri),
    .halted(halted), .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en),
    .osc_en(osc_en), .wake_vld(wake_vld), .wake_id(wake_id)
  );

  int    checks = 0;
  int    fails  = 0;
  int    cycles = 0;
  string cur_req = "R1";

  // behavioural reference model: 0 running, 1 window, 2 halted
  int mstate = 0;
  int left   = 0;
  int mmode  = 0;
  bit pn = 0, pe = 0, prev_n = 0, prev_e = 0;
  int q[$];

  always @(posedge clk) begin
    bit ne, ee, busy;
    cycles++;
    if (!rst_n) begin
      mstate = 0; left = 0; mmode = 0; pn = 0; pe = 0;
      prev_n = 0; prev_e = 0; q.delete();
    end else begin
      ne = nmi_lvl && !prev_n;
      ee = ext_lvl && !prev_e;
      prev_n = nmi_lvl;
      prev_e = ext_lvl;
      busy = (q.size() > 0);
      if (busy) void'(q.pop_front());
      case (mstate)
        0: if (!busy && halt_req) begin
             mmode = halt_mode;
             if (halt_mode >= 2) begin mstate = 1; left = WIN - 1; end
             else mstate = 2;
           end
        1: begin
             if (ne) pn = 1;
             if (ee) pe = 1;
             if (left == 0) mstate = 2; else left--;
           end
        default: if (ne || ee || oth_req) begin
             bit n2, e2;
             n2 = pn || ne;
             e2 = pe || ee;
             if (n2) q.push_back(0);
             if (e2 && oth_req) begin
               if (oth_pri > EXT_LVL) begin q.push_back(2); q.push_back(1); end
               else begin q.push_back(1); q.push_back(2); end
             end else if (e2) q.push_back(1);
             else if (oth_req) q.push_back(2);
             pn = 0; pe = 0; mstate = 0;
           end
      endcase
    end
  end

  task automatic chk(string tag, logic [6:0] act, logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s {halted,core,periph,osc,vld,id} act=%b exp=%b t=%0t",
               tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic [6:0] e;
    bit hh;
    hh = (mstate == 2);
    e = {hh, !hh, !(hh && mmode >= 2), !(hh && mmode == 3),
         q.size() > 0, (q.size() > 0) ? 2'(q[0]) : 2'd3};
    chk(cur_req, {halted, core_clk_en, periph_clk_en, osc_en, wake_vld, wake_id}, e);
  end

  always @(negedge clk) begin
    if (cycles > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_halt(logic [1:0] m);
    halt_req = 1; halt_mode = m; cyc(1); halt_req = 0;
  endtask

  task automatic pulse_nmi(); nmi_lvl = 1; cyc(1); nmi_lvl = 0; endtask
  task automatic pulse_ext(); ext_lvl = 1; cyc(1); ext_lvl = 0; endtask
  task automatic pulse_oth(logic [2:0] p);
    oth_req = 1; oth_pri = p; cyc(1); oth_req = 0;
  endtask

  initial begin
    cur_req = "R1"; cyc(3); rst_n = 1; cyc(2);
    // R2 run-halt, woken by other request (R6)
    cur_req = "R2"; do_halt(2'd0); cyc(3);
    cur_req = "R6"; pulse_oth(3'd1); cyc(3);
    // R2 full idle, woken by external edge
    cur_req = "R2"; do_halt(2'd1); cyc(2); pulse_ext(); cyc(3);
    // R3/R4 light idle, woken by non-maskable
    cur_req = "R3"; do_halt(2'd2); cyc(6);
    cur_req = "R4"; pulse_nmi(); cyc(3);
    // R5 stop, external edge in window, then R7 non-maskable wake
    cur_req = "R5"; do_halt(2'd3); pulse_ext(); cyc(6);
    cur_req = "R7"; pulse_nmi(); cyc(4);
    // R8 merge of pending and new external
    cur_req = "R8"; do_halt(2'd2); pulse_ext(); cyc(5); pulse_ext(); cyc(4);
    // R7 other above external
    cur_req = "R7"; do_halt(2'd3); cyc(1); pulse_ext(); cyc(5); pulse_oth(3'd6); cyc(4);
    // R7 tie goes to external
    do_halt(2'd2); pulse_ext(); cyc(5); pulse_oth(3'd4); cyc(4);
    // R9 halt_req in window and while halted
    cur_req = "R9"; do_halt(2'd2); do_halt(2'd0); cyc(4); do_halt(2'd1); cyc(2);
    pulse_nmi(); do_halt(2'd0); cyc(3);
    // R9 halt_req during a dispatch cycle
    do_halt(2'd3); pulse_nmi(); cyc(5); pulse_ext(); do_halt(2'd0); cyc(3);
    // R10 reset discards pending
    cur_req = "R10"; do_halt(2'd2); pulse_ext(); rst_n = 0; cyc(1); rst_n = 1; cyc(2);
    do_halt(2'd2); cyc(6); pulse_oth(3'd2); cyc(4);
    // R11 other request held through window
    cur_req = "R11"; oth_pri = 3'd5; oth_req = 1; do_halt(2'd3); cyc(6); oth_req = 0; cyc(3);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule